// File: doc/BRIEF.md
# Prioritized CPU Interrupt Controller

This block sits beside the instruction sequencer of an 8-bit CPU core and decides, at each instruction boundary, whether control is diverted to an interrupt handler. It watches a level-sensitive maskable request and an edge-sensitive non-maskable request. It keeps the two interrupt-enable flip-flops and the selected acknowledge mode, and it tracks the halted state. On entry it reports where execution continues. That report takes one of three forms: a direct target address, a pointer into a handler table in memory, or an opcode that a device placed on the bus for the core to execute.

A non-maskable entry goes straight to a fixed address. A maskable entry first asks the core's bus logic for an acknowledge cycle. That cycle lasts a fixed number of clocks so that the device has time to drive its byte. The block samples the byte in the last acknowledge clock and then issues the entry report. The core drives `end_of_instr` high for one clock on the last clock of each instruction. While halted, the core keeps issuing these strobes as it executes no-ops. The table page comes from the core's page register.

Top module: `cpu_irq_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `halt_n` is 1, `ack_req` is 0 and `entry_valid` is 0. Both enable flip-flops are clear and the mode is 0, so a maskable request is not taken until enabled.
- R2: A falling edge on `nmi_n` is latched, even from a one-cycle pulse. At the next `end_of_instr` after the latch, `entry_valid` is 1 in the following cycle, with `entry_kind` = 0 (direct) and `entry_addr` = 0x0066.
- R3: When a latched non-maskable request and an enabled maskable request are both present at the same boundary, only the non-maskable entry is made and no acknowledge cycle starts.
- R4: A low `irq_n` at an `end_of_instr` clock is accepted only when the main enable flip-flop is set. Otherwise it has no effect on `ack_req` or `entry_valid`.
- R5: Accepting a maskable request raises `ack_req` for exactly 3 cycles, starting the cycle after the boundary. `vec_byte` and `page_reg` are sampled at the end of the last of these cycles. `entry_valid` is 1 in the cycle after `ack_req` falls.
- R6: In mode 1, the entry is direct (`entry_kind` = 0) to 0x0038, whatever the vector byte.
- R7: In mode 2 (and mode value 3), the entry is an indirect pointer (`entry_kind` = 1) with `entry_addr` = {page_reg, vec_byte}.
- R8: In mode 0, a vector byte of the form 11ttt111 gives a direct entry to address ttt×8. Any other byte gives `entry_kind` = 2 (execute), with the byte on `entry_op`.
- R9: Accepting a maskable request clears both enable flip-flops, so a further request is ignored until `cmd_ei` is given.
- R10: A non-maskable entry copies the main enable into the shadow and clears the main enable. `cmd_retn` copies the shadow back into the main enable.
- R11: `cmd_ei` sets both enable flip-flops and `cmd_di` clears both.
- R12: `cmd_halt` drives `halt_n` low from the next cycle. It stays low across boundaries with no accepted interrupt and goes high in the same cycle that `ack_req` rises or that a non-maskable `entry_valid` appears.
- R13: While halted with the maskable request disabled, a low `irq_n` does not end the halt, but a non-maskable request does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, falling edge |
| end_of_instr | input | 1 | Last clock of the current instruction |
| cmd_ei | input | 1 | Enable maskable requests |
| cmd_di | input | 1 | Disable maskable requests |
| cmd_retn | input | 1 | Return from non-maskable handler |
| cmd_halt | input | 1 | Enter the halted state |
| cmd_mode_set | input | 1 | Load `cmd_mode` |
| cmd_mode | input | 2 | Acknowledge mode 0, 1 or 2 (3 acts as 2) |
| page_reg | input | 8 | Upper byte of the handler table pointer |
| vec_byte | input | 8 | Byte driven by the device during acknowledge |
| ack_req | output | 1 | Acknowledge cycle in progress |
| entry_valid | output | 1 | One-cycle entry report |
| entry_kind | output | 2 | 0 direct, 1 table pointer, 2 execute opcode |
| entry_addr | output | 16 | Target address or table pointer |
| entry_op | output | 8 | Opcode to execute when kind is 2 |
| halt_n | output | 1 | Active-low halted indication |

## Verification
Maskable entries are run in each mode with distinct vector bytes. A restart-form byte and a plain byte in mode 0 separate the direct-restart decode from the execute path. A byte in mode 1 that would have decoded differently shows that the byte is ignored. In mode 2, an unusual page and byte pair exposes swapped halves.

Requests are also presented while disabled, after an acceptance, and after a non-maskable entry with and without the restore command. These runs separate the main and shadow enable flip-flops. Coincident requests check the priority. A short non-maskable pulse arriving long before the boundary checks the latch. Halt runs with and without the enable show which sources end the halted state.

// File: rtl/cpu_irq_arbiter.sv
module cpu_irq_arbiter #(
  parameter int DW         = 8,
  parameter int AW         = 16,
  parameter int ACK_WAITS  = 2,
  parameter logic [AW-1:0] NMI_TARGET   = 16'h0066,
  parameter logic [AW-1:0] FIXED_TARGET = 16'h0038
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_n,
  input  logic          nmi_n,
  input  logic          end_of_instr,
  input  logic          cmd_ei,
  input  logic          cmd_di,
  input  logic          cmd_retn,
  input  logic          cmd_halt,
  input  logic          cmd_mode_set,
  input  logic [1:0]    cmd_mode,
  input  logic [DW-1:0] page_reg,
  input  logic [DW-1:0] vec_byte,
  output logic          ack_req,
  output logic          entry_valid,
  output logic [1:0]    entry_kind,
  output logic [AW-1:0] entry_addr,
  output logic [DW-1:0] entry_op,
  output logic          halt_n
);

  localparam int CW = $clog2(ACK_WAITS + 2);
  localparam logic [1:0] KIND_DIRECT = 2'd0;
  localparam logic [1:0] KIND_TABLE  = 2'd1;
  localparam logic [1:0] KIND_EXEC   = 2'd2;

  logic          iff1, iff2, halted, nmi_q, nmi_pend;
  logic [1:0]    mode, mode_cap;
  logic [CW-1:0] cnt;

  wire nmi_fall  = nmi_q & ~nmi_n;
  wire idle      = ~ack_req;
  wire take_nmi  = idle & end_of_instr & nmi_pend;
  wire take_irq  = idle & end_of_instr & ~nmi_pend & ~irq_n & iff1;
  wire ack_last  = ack_req & (cnt == CW'(ACK_WAITS));
  wire is_rst_op = (vec_byte[7:6] == 2'b11) & (vec_byte[2:0] == 3'b111);

  assign halt_n = ~halted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_n;
      nmi_pend <= nmi_fall | (nmi_pend & ~take_nmi);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
      mode <= 2'd0;
    end else begin
      if (take_nmi) begin
        iff2 <= iff1;
        iff1 <= 1'b0;
      end else if (take_irq || cmd_di) begin
        iff1 <= 1'b0;
        iff2 <= 1'b0;
      end else if (cmd_ei) begin
        iff1 <= 1'b1;
        iff2 <= 1'b1;
      end else if (cmd_retn) begin
        iff1 <= iff2;
      end
      if (cmd_mode_set) mode <= cmd_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  halted <= 1'b0;
    else if (take_nmi || take_irq) halted <= 1'b0;
    else if (cmd_halt)           halted <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_req  <= 1'b0;
      cnt      <= '0;
      mode_cap <= 2'd0;
    end else if (take_irq) begin
      ack_req  <= 1'b1;
      cnt      <= '0;
      mode_cap <= mode;
    end else if (ack_last) begin
      ack_req  <= 1'b0;
    end else if (ack_req) begin
      cnt      <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_valid <= 1'b0;
      entry_kind  <= KIND_DIRECT;
      entry_addr  <= '0;
      entry_op    <= '0;
    end else begin
      entry_valid <= take_nmi | ack_last;
      if (take_nmi) begin
        entry_kind <= KIND_DIRECT;
        entry_addr <= NMI_TARGET;
      end else if (ack_last) begin
        entry_op <= vec_byte;
        case (mode_cap)
          2'd0: begin
            if (is_rst_op) begin
              entry_kind <= KIND_DIRECT;
              entry_addr <= {{(AW-6){1'b0}}, vec_byte[5:3], 3'b000};
            end else begin
              entry_kind <= KIND_EXEC;
              entry_addr <= '0;
            end
          end
          2'd1: begin
            entry_kind <= KIND_DIRECT;
            entry_addr <= FIXED_TARGET;
          end
          default: begin
            entry_kind <= KIND_TABLE;
            entry_addr <= {page_reg, vec_byte};
          end
        endcase
      end
    end
  end

  // R2
  nmi_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |=> entry_valid && entry_kind == KIND_DIRECT && entry_addr == NMI_TARGET);

  // R3
  nmi_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && end_of_instr && nmi_pend) |=> !ack_req);

  // R4
  irq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req) |-> $past(iff1) && !$past(irq_n));

  // R5
  ack_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_req) |-> entry_valid);

  // R9
  ack_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req) |-> !iff1 && !iff2);

  // R12
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_n) |-> $past(cmd_halt));

endmodule

// File: tb/cpu_irq_arbiter_tb.sv
module cpu_irq_arbiter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_n = 1'b1, nmi_n = 1'b1, end_of_instr = 1'b0;
  logic cmd_ei = 0, cmd_di = 0, cmd_retn = 0, cmd_halt = 0, cmd_mode_set = 0;
  logic [1:0] cmd_mode = 2'd0;
  logic [7:0] page_reg = 8'h00, vec_byte = 8'h00;
  logic ack_req, entry_valid, halt_n;
  logic [1:0] entry_kind;
  logic [15:0] entry_addr;
  logic [7:0] entry_op;

  always #5 clk = ~clk;

  cpu_irq_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
    .end_of_instr(end_of_instr), .cmd_ei(cmd_ei), .cmd_di(cmd_di),
    .cmd_retn(cmd_retn), .cmd_halt(cmd_halt), .cmd_mode_set(cmd_mode_set),
    .cmd_mode(cmd_mode), .page_reg(page_reg), .vec_byte(vec_byte),
    .ack_req(ack_req), .entry_valid(entry_valid), .entry_kind(entry_kind),
    .entry_addr(entry_addr), .entry_op(entry_op), .halt_n(halt_n));

  int errors = 0, checks = 0, entries = 0;
  string cur_req = "R1";
  logic [1:0] last_kind;
  logic [15:0] last_addr;
  logic [7:0] last_op;

  bit m_iff1, m_iff2, m_halt, m_pend, m_nmiq, m_inack, m_gv;
  int m_mode, m_modec, m_cnt, m_kind, m_addr, m_op;

  always @(posedge clk) begin
    bit fall, tn, ti;
    if (!rst_n) begin
      m_iff1 = 0; m_iff2 = 0; m_halt = 0; m_pend = 0; m_nmiq = 1;
      m_inack = 0; m_gv = 0; m_mode = 0; m_modec = 0; m_cnt = 0;
    end else begin
      fall = m_nmiq && !nmi_n;
      tn = !m_inack && end_of_instr && m_pend;
      ti = !m_inack && end_of_instr && !m_pend && !irq_n && m_iff1;
      m_gv = 0;
      if (m_inack) begin
        if (m_cnt == 2) begin
          m_inack = 0; m_gv = 1; m_op = vec_byte;
          if (m_modec == 1) begin m_kind = 0; m_addr = 'h38; end
          else if (m_modec >= 2) begin m_kind = 1; m_addr = page_reg * 256 + vec_byte; end
          else if (vec_byte[7:6] == 2'b11 && vec_byte[2:0] == 3'b111) begin
            m_kind = 0; m_addr = vec_byte[5:3] * 8;
          end else begin m_kind = 2; m_addr = 0; end
        end else m_cnt++;
      end
      if (tn) begin m_gv = 1; m_kind = 0; m_addr = 'h66; end
      if (ti) begin m_inack = 1; m_cnt = 0; m_modec = m_mode; end
      if (tn) begin m_iff2 = m_iff1; m_iff1 = 0; end
      else if (ti || cmd_di) begin m_iff1 = 0; m_iff2 = 0; end
      else if (cmd_ei) begin m_iff1 = 1; m_iff2 = 1; end
      else if (cmd_retn) m_iff1 = m_iff2;
      if (cmd_mode_set) m_mode = cmd_mode;
      if (tn || ti) m_halt = 0; else if (cmd_halt) m_halt = 1;
      m_pend = fall || (m_pend && !tn);
      m_nmiq = nmi_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(ack_req == m_inack, {cur_req, " ack_req"}, ack_req, m_inack);
      chk(halt_n == !m_halt, {cur_req, " halt_n"}, halt_n, !m_halt);
      chk(entry_valid == m_gv, {cur_req, " entry_valid"}, entry_valid, m_gv);
      if (entry_valid && m_gv) begin
        chk(entry_kind == m_kind[1:0], {cur_req, " kind"}, entry_kind, m_kind);
        chk(entry_addr == m_addr[15:0], {cur_req, " addr"}, entry_addr, m_addr);
        if (m_kind == 2) chk(entry_op == m_op[7:0], {cur_req, " op"}, entry_op, m_op);
      end
      if (entry_valid) begin
        entries++; last_kind = entry_kind; last_addr = entry_addr; last_op = entry_op;
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic pulse_cmd(input int which);
    case (which)
      0: cmd_ei = 1; 1: cmd_di = 1; 2: cmd_retn = 1; default: cmd_halt = 1;
    endcase
    tick();
    cmd_ei = 0; cmd_di = 0; cmd_retn = 0; cmd_halt = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    cmd_mode = m; cmd_mode_set = 1; tick(); cmd_mode_set = 0;
  endtask

  task automatic boundary();
    end_of_instr = 1; tick(); end_of_instr = 0;
  endtask

  task automatic nmi_pulse();
    nmi_n = 0; tick(); nmi_n = 1;
  endtask

  task automatic maskable(input logic [1:0] m, input logic [7:0] b);
    int e0;
    set_mode(m); pulse_cmd(0);
    vec_byte = b; irq_n = 0; e0 = entries;
    boundary(); irq_n = 1; tick(6);
    chk(entries == e0 + 1, {cur_req, " entry count"}, entries - e0, 1);
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int e0;
    tick(4);
    cur_req = "R1";
    chk(halt_n == 1, "R1 halt_n in reset", halt_n, 1);
    chk(ack_req == 0, "R1 ack_req in reset", ack_req, 0);
    rst_n = 1; tick();
    chk(entry_valid == 0, "R1 entry_valid after reset", entry_valid, 0);
    irq_n = 0; boundary(); tick(4); irq_n = 1;
    chk(entries == 0, "R1 no entry while disabled", entries, 0);

    cur_req = "R8";
    maskable(2'd0, 8'hFF);
    chk(last_kind == 0 && last_addr == 16'h0038, "R8 restart ff", last_addr, 16'h0038);
    maskable(2'd0, 8'hD7);
    chk(last_addr == 16'h0010, "R8 restart d7", last_addr, 16'h0010);
    maskable(2'd0, 8'h3E);
    chk(last_kind == 2 && last_op == 8'h3E, "R8 execute op", last_op, 8'h3E);

    cur_req = "R6";
    maskable(2'd1, 8'hC7);
    chk(last_kind == 0 && last_addr == 16'h0038, "R6 fixed target", last_addr, 16'h0038);

    cur_req = "R7";
    page_reg = 8'h3C;
    maskable(2'd2, 8'h5A);
    chk(last_kind == 1 && last_addr == 16'h3C5A, "R7 table pointer", last_addr, 16'h3C5A);
    maskable(2'd3, 8'h01);
    chk(last_addr == 16'h3C01, "R7 mode value 3", last_addr, 16'h3C01);

    cur_req = "R5";
    set_mode(2'd1); pulse_cmd(0); irq_n = 0; boundary(); irq_n = 1;
    chk(ack_req == 1, "R5 ack first cycle", ack_req, 1);
    tick(2);
    chk(ack_req == 1, "R5 ack third cycle", ack_req, 1);
    tick();
    chk(ack_req == 0 && entry_valid == 1, "R5 report after ack", entry_valid, 1);
    tick(2);

    cur_req = "R9";
    e0 = entries; irq_n = 0; boundary(); tick(5); irq_n = 1;
    chk(entries == e0, "R9 disabled after accept", entries - e0, 0);

    cur_req = "R4";
    pulse_cmd(0); pulse_cmd(1);
    e0 = entries; irq_n = 0; boundary(); tick(5); irq_n = 1;
    chk(entries == e0, "R4 ignored after di", entries - e0, 0);

    cur_req = "R11";
    pulse_cmd(0); e0 = entries; irq_n = 0; boundary(); irq_n = 1; tick(5);
    chk(entries == e0 + 1, "R11 taken after ei", entries - e0, 1);

    cur_req = "R2";
    nmi_pulse(); tick(7);
    e0 = entries; boundary();
    chk(entry_valid == 1 && entry_addr == 16'h0066, "R2 nmi target", entry_addr, 16'h0066);
    tick(3);
    chk(entries == e0 + 1, "R2 single nmi entry", entries - e0, 1);

    cur_req = "R3";
    pulse_cmd(0); nmi_pulse(); tick();
    irq_n = 0; boundary();
    chk(entry_addr == 16'h0066 && ack_req == 0, "R3 nmi wins", entry_addr, 16'h0066);
    tick(4); irq_n = 1;

    cur_req = "R10";
    e0 = entries; irq_n = 0; boundary(); tick(5);
    chk(entries == e0, "R10 main enable cleared by nmi", entries - e0, 0);
    pulse_cmd(2); boundary(); irq_n = 1; tick(5);
    chk(entries == e0 + 1, "R10 retn restores", entries - e0, 1);

    cur_req = "R12";
    pulse_cmd(3);
    chk(halt_n == 0, "R12 halt asserted", halt_n, 0);
    boundary(); boundary(); tick(2);
    chk(halt_n == 0, "R12 halt held", halt_n, 0);
    pulse_cmd(0); irq_n = 0; boundary(); irq_n = 1;
    chk(halt_n == 1 && ack_req == 1, "R12 halt leaves with ack", halt_n, 1);
    tick(5);

    cur_req = "R13";
    pulse_cmd(1); pulse_cmd(3);
    irq_n = 0; boundary(); boundary(); tick(3); irq_n = 1;
    chk(halt_n == 0, "R13 disabled irq keeps halt", halt_n, 0);
    nmi_pulse(); tick(); boundary();
    chk(halt_n == 1 && entry_valid == 1, "R13 nmi ends halt", halt_n, 1);
    tick(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule